// File: doc/BRIEF.md
# Ring-Buffer Byte DMA Channel

This block is one channel of a byte-wide DMA engine that moves bytes between a serial peripheral and a circular buffer in memory. A build-time parameter picks the direction. In the outbound direction the channel fetches bytes from memory and offers them on a valid/ready stream. In the inbound direction it accepts bytes from a valid/ready stream and stores them in memory. Software configures the channel and observes it through a 32-bit register port with single-cycle writes and combinational reads. A one-beat request port carries the byte reads and writes to memory.

Software and hardware share the ring through two pointers. Each pointer has an offset field and, one bit above it, a wrap flag. In the outbound direction software owns the write pointer and hardware owns the read pointer. Inbound, the roles are reversed. The channel derives the occupied and free byte counts from the two pointers. It raises sticky interrupt flags when a programmable threshold is crossed. It also offers three controls: a drain request that hardware acknowledges, a stop handshake that lets the byte in flight finish, and a warm reset that returns the channel to idle.

Top module: `rdma_channel`

## Requirements
- R1: The pointer that hardware owns moves forward by one for each accepted memory beat. When the offset plus one reaches the ring length, the offset returns to 0 and the wrap flag (bit OFF_W, bit 16 by default) inverts.
- R2: The occupied count is read at byte offset 0x3C and the free count at 0x40. When both wrap flags are equal, the occupied count is write offset minus read offset. When they differ, it is write offset plus length minus read offset. The free count is length minus occupied.
- R3: Outbound: each read request carries the address {ext bit, base + read offset}. Each fetched byte is held and presented on tx_data with tx_valid high, stays unchanged until tx_ready, and bytes leave in ring order.
- R4: Inbound: a byte on rx_data is written to {ext bit, base + write offset}. rx_ready is high exactly in the cycle the memory write is acknowledged.
- R5: No memory request is made while the channel is disabled or stopped. Outbound, none is made when the occupied count is 0. Inbound, none is made when the free count is 0.
- R6: Software writes the pointer it owns (write pointer 0x2C outbound, read pointer 0x30 inbound). Writes to the pointer that hardware owns, and to the count registers, are ignored.
- R7: Flag register 0x00, enable register 0x04. Flag bit 0 sets while enable bit 0 is 1 and the threshold (0x28) is met: outbound the free count must be at least the threshold, inbound the occupied count must be at least the threshold. Inbound flag bit 1 sets while enable bit 1 is 1 and the free count is 0. Writing 1 to a flag bit clears it, but a set in the same cycle wins. irq is the OR of the flags.
- R8: Writing 1 to bit 0 of 0x14 raises a drain request that reads back as 1. Hardware clears it once no byte is held and, outbound, the occupied count is 0.
- R9: With bit 0 of 0x10 set, no new byte is started. The enable bit (0x08) drops to 0 once no byte is held. Writes of 1 to the enable bit have no effect while stop is set.
- R10: Writing 1 to bit 0 of 0x0C clears the enable, stop and drain bits, the flags, both pointers and the held byte. The register at 0x0C always reads 0.
- R11: Bit 0 of 0x54 drives address bit 32 of every memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | ADDR_W+1 | Byte address including the extension bit |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with mem_ack |
| mem_ack | input | 1 | Beat accepted this cycle |
| tx_valid | output | 1 | Outbound byte available |
| tx_data | output | 8 | Outbound byte |
| tx_ready | input | 1 | Peripheral takes the outbound byte |
| rx_valid | input | 1 | Inbound byte available |
| rx_data | input | 8 | Inbound byte |
| rx_ready | output | 1 | Inbound byte accepted |
| irq | output | 1 | Channel interrupt |

## Verification
The functions most likely to meet in one cycle are a hardware flag set and a software write-one-to-clear of the same flag. The bench provokes this by clearing a flag while its threshold condition still holds (free count at or above threshold outbound, ring full inbound) and requires the flag to read 1 afterwards. It then moves the condition away and requires the same clear to take effect. A second case lets hardware advance its pointer while software rewrites the opposite pointer, and judges it from the final pointer and count values and from the per-beat address and data model.

// File: rtl/rdma_pkg.sv
package rdma_pkg;

   // Register byte offsets
   localparam logic [7:0] RA_FLAG  = 8'h00;
   localparam logic [7:0] RA_IEN   = 8'h04;
   localparam logic [7:0] RA_EN    = 8'h08;
   localparam logic [7:0] RA_RST   = 8'h0C;
   localparam logic [7:0] RA_STOP  = 8'h10;
   localparam logic [7:0] RA_FLUSH = 8'h14;
   localparam logic [7:0] RA_BASE  = 8'h1C;
   localparam logic [7:0] RA_LEN   = 8'h24;
   localparam logic [7:0] RA_THR   = 8'h28;
   localparam logic [7:0] RA_WPT   = 8'h2C;
   localparam logic [7:0] RA_RPT   = 8'h30;
   localparam logic [7:0] RA_VALID = 8'h3C;
   localparam logic [7:0] RA_LEFT  = 8'h40;
   localparam logic [7:0] RA_DBG   = 8'h50;
   localparam logic [7:0] RA_EXT   = 8'h54;

   // Debug status layout (LSB = en)
   typedef struct packed {
      logic held;
      logic busy;
      logic flush;
      logic stop;
      logic en;
   } rdma_dbg_t;

endpackage

// File: rtl/rdma_ptr_step.sv
module rdma_ptr_step #(
   parameter int OFF_W = 16
) (
   input  logic [OFF_W:0] ptr_i,
   input  logic [OFF_W:0] len_i,
   output logic [OFF_W:0] ptr_o
);
   localparam int PW = OFF_W + 1;

   logic [PW-1:0] inc;

   always_comb begin
      inc = {1'b0, ptr_i[OFF_W-1:0]} + PW'(1);
      if (inc >= len_i) begin
         ptr_o = {~ptr_i[OFF_W], {OFF_W{1'b0}}};
      end else begin
         ptr_o = {ptr_i[OFF_W], inc[OFF_W-1:0]};
      end
   end
endmodule

// File: rtl/rdma_occupancy.sv
module rdma_occupancy #(
   parameter int OFF_W = 16
) (
   input  logic [OFF_W:0] wpt_i,
   input  logic [OFF_W:0] rpt_i,
   input  logic [OFF_W:0] len_i,
   output logic [OFF_W:0] filled_o,
   output logic [OFF_W:0] free_o
);
   localparam int PW = OFF_W + 1;

   logic [PW-1:0] w_off, r_off;

   always_comb begin
      w_off = {1'b0, wpt_i[OFF_W-1:0]};
      r_off = {1'b0, rpt_i[OFF_W-1:0]};
      if (wpt_i[OFF_W] == rpt_i[OFF_W]) begin
         filled_o = w_off - r_off;
      end else begin
         filled_o = w_off + len_i - r_off;
      end
      free_o = len_i - filled_o;
   end
endmodule

// File: rtl/rdma_mover.sv
module rdma_mover #(
   parameter bit IS_TX = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wreset,
   input  logic       go,
   input  logic       mem_ack,
   input  logic [7:0] mem_rdata,
   input  logic       tx_ready,
   input  logic       rx_valid,
   input  logic [7:0] rx_data,
   output logic       mem_req,
   output logic       mem_we,
   output logic [7:0] mem_wdata,
   output logic       tx_valid,
   output logic [7:0] tx_data,
   output logic       rx_ready,
   output logic       beat,
   output logic       held
);
   generate
      if (IS_TX) begin : g_tx
         logic       full_q;
         logic [7:0] byte_q;
         logic       unused_rx;

         assign unused_rx = ^{rx_valid, rx_data};
         assign mem_req   = go & ~full_q;
         assign mem_we    = 1'b0;
         assign mem_wdata = 8'h00;
         assign beat      = mem_req & mem_ack;
         assign tx_valid  = full_q;
         assign tx_data   = byte_q;
         assign rx_ready  = 1'b0;
         assign held      = full_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               full_q <= 1'b0;
               byte_q <= 8'h00;
            end else if (wreset) begin
               full_q <= 1'b0;
            end else if (beat) begin
               full_q <= 1'b1;
               byte_q <= mem_rdata;
            end else if (full_q && tx_ready) begin
               full_q <= 1'b0;
            end
         end
      end else begin : g_rx
         logic unused_tx;

         assign unused_tx = ^{clk, rst_n, wreset, tx_ready, mem_rdata};
         assign mem_req   = go & rx_valid;
         assign mem_we    = 1'b1;
         assign mem_wdata = rx_data;
         assign beat      = mem_req & mem_ack;
         assign rx_ready  = beat;
         assign tx_valid  = 1'b0;
         assign tx_data   = 8'h00;
         assign held      = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/rdma_channel.sv
module rdma_channel
   import rdma_pkg::*;
#(
   parameter int OFF_W  = 16,
   parameter int ADDR_W = 32,
   parameter bit IS_TX  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [7:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W:0]   mem_addr,
   output logic [7:0]        mem_wdata,
   input  logic [7:0]        mem_rdata,
   input  logic              mem_ack,
   output logic              tx_valid,
   output logic [7:0]        tx_data,
   input  logic              tx_ready,
   input  logic              rx_valid,
   input  logic [7:0]        rx_data,
   output logic              rx_ready,
   output logic              irq
);
   localparam int PW = OFF_W + 1;

   generate
      if (OFF_W < 2 || OFF_W > 24) begin : g_bad_off
         $error("rdma_channel: OFF_W out of range");
      end
      if (ADDR_W <= OFF_W || ADDR_W > 32) begin : g_bad_addr
         $error("rdma_channel: ADDR_W out of range");
      end
   endgenerate

   logic              en_q, stop_q, flush_q, ext_q;
   logic [1:0]        ien_q, flag_q, flag_set, flag_clr;
   logic [ADDR_W-1:0] base_q;
   logic [PW-1:0]     len_q, thr_q, wpt_q, rpt_q;
   logic [PW-1:0]     hw_ptr, hw_nxt, filled, free;
   logic              beat, held, avail, go, drained;
   logic              w_flag, w_ien, w_en, w_rst, w_stop, w_flush;
   logic              w_base, w_len, w_thr, w_wpt, w_rpt, w_ext, wreset;

   // write decode
   assign w_flag  = reg_we && reg_addr == RA_FLAG;
   assign w_ien   = reg_we && reg_addr == RA_IEN;
   assign w_en    = reg_we && reg_addr == RA_EN;
   assign w_rst   = reg_we && reg_addr == RA_RST;
   assign w_stop  = reg_we && reg_addr == RA_STOP;
   assign w_flush = reg_we && reg_addr == RA_FLUSH;
   assign w_base  = reg_we && reg_addr == RA_BASE;
   assign w_len   = reg_we && reg_addr == RA_LEN;
   assign w_thr   = reg_we && reg_addr == RA_THR;
   assign w_wpt   = reg_we && reg_addr == RA_WPT;
   assign w_rpt   = reg_we && reg_addr == RA_RPT;
   assign w_ext   = reg_we && reg_addr == RA_EXT;
   assign wreset  = w_rst & reg_wdata[0];

   // hardware-side pointer selection
   generate
      if (IS_TX) begin : g_hw_rd
         assign hw_ptr = rpt_q;
         assign avail  = filled != '0;
      end else begin : g_hw_wr
         assign hw_ptr = wpt_q;
         assign avail  = free != '0;
      end
   endgenerate

   rdma_ptr_step #(.OFF_W(OFF_W)) step_i (
      .ptr_i (hw_ptr),
      .len_i (len_q),
      .ptr_o (hw_nxt)
   );

   rdma_occupancy #(.OFF_W(OFF_W)) occ_i (
      .wpt_i    (wpt_q),
      .rpt_i    (rpt_q),
      .len_i    (len_q),
      .filled_o (filled),
      .free_o   (free)
   );

   assign go = en_q & ~stop_q & avail;

   rdma_mover #(.IS_TX(IS_TX)) mover_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wreset    (wreset),
      .go        (go),
      .mem_ack   (mem_ack),
      .mem_rdata (mem_rdata),
      .tx_ready  (tx_ready),
      .rx_valid  (rx_valid),
      .rx_data   (rx_data),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_wdata (mem_wdata),
      .tx_valid  (tx_valid),
      .tx_data   (tx_data),
      .rx_ready  (rx_ready),
      .beat      (beat),
      .held      (held)
   );

   assign mem_addr = {ext_q, base_q + ADDR_W'(hw_ptr[OFF_W-1:0])};
   assign drained  = ~held & (~IS_TX | (filled == '0));

   // configuration registers (kept across warm reset)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_q  <= '0;
         base_q <= '0;
         len_q  <= '0;
         thr_q  <= '0;
         ext_q  <= 1'b0;
      end else begin
         if (w_ien)  ien_q  <= reg_wdata[1:0];
         if (w_base) base_q <= reg_wdata[ADDR_W-1:0];
         if (w_len)  len_q  <= reg_wdata[PW-1:0];
         if (w_thr)  thr_q  <= reg_wdata[PW-1:0];
         if (w_ext)  ext_q  <= reg_wdata[0];
      end
   end

   // control bits
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         stop_q  <= 1'b0;
         flush_q <= 1'b0;
      end else if (wreset) begin
         en_q    <= 1'b0;
         stop_q  <= 1'b0;
         flush_q <= 1'b0;
      end else begin
         if (stop_q && !held) begin
            en_q <= 1'b0;
         end else if (w_en) begin
            en_q <= reg_wdata[0] & ~stop_q;
         end
         if (w_stop) stop_q <= reg_wdata[0];
         if (w_flush && reg_wdata[0]) begin
            flush_q <= 1'b1;
         end else if (flush_q && drained) begin
            flush_q <= 1'b0;
         end
      end
   end

   // write pointer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wpt_q <= '0;
      end else if (wreset) begin
         wpt_q <= '0;
      end else if (IS_TX) begin
         if (w_wpt) wpt_q <= reg_wdata[PW-1:0];
      end else if (beat) begin
         wpt_q <= hw_nxt;
      end
   end

   // read pointer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rpt_q <= '0;
      end else if (wreset) begin
         rpt_q <= '0;
      end else if (!IS_TX) begin
         if (w_rpt) rpt_q <= reg_wdata[PW-1:0];
      end else if (beat) begin
         rpt_q <= hw_nxt;
      end
   end

   // interrupt flags: set beats write-one-to-clear
   always_comb begin
      flag_set[0] = ien_q[0] & (IS_TX ? (free >= thr_q) : (filled >= thr_q));
      flag_set[1] = ~IS_TX & ien_q[1] & (free == '0);
      flag_clr    = w_flag ? reg_wdata[1:0] : 2'b00;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= '0;
      end else if (wreset) begin
         flag_q <= '0;
      end else begin
         flag_q <= (flag_q & ~flag_clr) | flag_set;
      end
   end

   assign irq = |flag_q;

   // read mux
   rdma_dbg_t dbg;
   always_comb begin
      dbg = '{held: held, busy: mem_req, flush: flush_q, stop: stop_q, en: en_q};
      case (reg_addr)
         RA_FLAG:  reg_rdata = 32'(flag_q);
         RA_IEN:   reg_rdata = 32'(ien_q);
         RA_EN:    reg_rdata = 32'(en_q);
         RA_STOP:  reg_rdata = 32'(stop_q);
         RA_FLUSH: reg_rdata = 32'(flush_q);
         RA_BASE:  reg_rdata = 32'(base_q);
         RA_LEN:   reg_rdata = 32'(len_q);
         RA_THR:   reg_rdata = 32'(thr_q);
         RA_WPT:   reg_rdata = 32'(wpt_q);
         RA_RPT:   reg_rdata = 32'(rpt_q);
         RA_VALID: reg_rdata = 32'(filled);
         RA_LEFT:  reg_rdata = 32'(free);
         RA_DBG:   reg_rdata = 32'(dbg);
         RA_EXT:   reg_rdata = 32'(ext_q);
         default:  reg_rdata = 32'h0;
      endcase
   end
endmodule

// File: rtl/rdma_chk.sv
module rdma_chk
   import rdma_pkg::*;
#(
   parameter int OFF_W = 16,
   parameter bit IS_TX = 1'b1
) (
   input logic           clk,
   input logic           rst_n,
   input logic           reg_we,
   input logic [7:0]     reg_addr,
   input logic           wr_bit0,
   input logic           mem_req,
   input logic           tx_valid,
   input logic           tx_ready,
   input logic [7:0]     tx_data,
   input logic           rx_ready,
   input logic           en_q,
   input logic           stop_q,
   input logic           flush_q,
   input logic           held,
   input logic [OFF_W:0] filled,
   input logic [OFF_W:0] free,
   input logic [OFF_W:0] len_q,
   input logic [OFF_W:0] wpt_q
);
   logic rst_wr, flush_wr;
   assign rst_wr   = reg_we && reg_addr == RA_RST && wr_bit0;
   assign flush_wr = reg_we && reg_addr == RA_FLUSH && wr_bit0;

   AST_REQ_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> en_q && !stop_q && (IS_TX ? filled != '0 : free != '0)); // R5

   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      filled <= len_q && (filled + free) == len_q); // R2

   AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      IS_TX && tx_valid && !tx_ready && !rst_wr |=> tx_valid && $stable(tx_data)); // R3

   AST_RX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !IS_TX && rx_ready && !rst_wr |=> wpt_q != $past(wpt_q)); // R4

   AST_STOP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      stop_q && !held |=> !en_q); // R9

   AST_FLUSH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      flush_q && !held && (!IS_TX || filled == '0) && !flush_wr |=> !flush_q); // R8

   AST_WARM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      rst_wr |=> !en_q && !stop_q && !flush_q && wpt_q == '0); // R10
endmodule

bind rdma_channel rdma_chk #(.OFF_W(OFF_W), .IS_TX(IS_TX)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_we   (reg_we),
   .reg_addr (reg_addr),
   .wr_bit0  (reg_wdata[0]),
   .mem_req  (mem_req),
   .tx_valid (tx_valid),
   .tx_ready (tx_ready),
   .tx_data  (tx_data),
   .rx_ready (rx_ready),
   .en_q     (en_q),
   .stop_q   (stop_q),
   .flush_q  (flush_q),
   .held     (held),
   .filled   (filled),
   .free     (free),
   .len_q    (len_q),
   .wpt_q    (wpt_q)
);

// File: tb/rdma_channel_tb_top.sv
`timescale 1ns/100ps
module rdma_channel_tb_top;
   import rdma_pkg::*;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;
   logic rst_n;

   // outbound instance signals
   logic        t_we;   logic [7:0] t_addr; logic [31:0] t_wdata, t_rdata;
   logic        t_req, t_mwe, t_ack, t_txv, t_txr, t_rxr, t_irq;
   logic [32:0] t_maddr; logic [7:0] t_mwdata, t_mrdata, t_txd;
   // inbound instance signals
   logic        r_we;   logic [7:0] r_addr; logic [31:0] r_wdata, r_rdata;
   logic        r_req, r_mwe, r_ack, r_txv, r_rxv, r_rxr, r_irq;
   logic [32:0] r_maddr; logic [7:0] r_mwdata, r_txd, rx_next;

   logic [7:0] tram [256];
   logic [7:0] rram [256];
   logic slow, tog;

   int checks = 0, errors = 0;
   int hw_off [2];
   int m_base [2];
   int m_len  [2];
   logic m_ext;
   int rx_exp;
   logic [7:0] tq [$];

   rdma_channel #(.IS_TX(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_we(t_we), .reg_addr(t_addr), .reg_wdata(t_wdata),
      .reg_rdata(t_rdata), .mem_req(t_req), .mem_we(t_mwe), .mem_addr(t_maddr),
      .mem_wdata(t_mwdata), .mem_rdata(t_mrdata), .mem_ack(t_ack), .tx_valid(t_txv),
      .tx_data(t_txd), .tx_ready(t_txr), .rx_valid(1'b0), .rx_data(8'h00),
      .rx_ready(t_rxr), .irq(t_irq));

   rdma_channel #(.IS_TX(1'b0)) rxdut_i (
      .clk(clk), .rst_n(rst_n), .reg_we(r_we), .reg_addr(r_addr), .reg_wdata(r_wdata),
      .reg_rdata(r_rdata), .mem_req(r_req), .mem_we(r_mwe), .mem_addr(r_maddr),
      .mem_wdata(r_mwdata), .mem_rdata(8'h00), .mem_ack(r_ack), .tx_valid(r_txv),
      .tx_data(r_txd), .tx_ready(1'b0), .rx_valid(r_rxv), .rx_data(rx_next),
      .rx_ready(r_rxr), .irq(r_irq));

   assign t_mrdata = tram[t_maddr[7:0]];
   assign t_ack = ~slow | tog;
   assign r_ack = ~slow | tog;

   always @(negedge clk) tog <= ~tog;
   always @(posedge clk) begin
      if (r_req && r_mwe && r_ack) rram[r_maddr[7:0]] <= r_mwdata;
      if (r_rxr) rx_next <= rx_next + 8'd1;
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step_model(input int s);
      hw_off[s]++;
      if (hw_off[s] >= m_len[s]) hw_off[s] = 0;
   endtask

   // behavioural reference model, compared every clock just before the edge
   always @(negedge clk) begin
      #1.5;
      if (rst_n) begin
         if (t_req) begin
            chk("R3 R11 fetch address", 64'(t_maddr),
                64'({m_ext, 32'(m_base[0] + hw_off[0])}));
            if (t_ack) begin
               tq.push_back(tram[t_maddr[7:0]]);
               step_model(0);
            end
         end
         if (t_txv && t_txr) begin
            if (tq.size() == 0) chk("R3 unexpected byte", 64'(1), 64'(0));
            else chk("R3 byte order", 64'(t_txd), 64'(tq.pop_front()));
         end
         if (r_rxr) begin
            chk("R4 store address", 64'(r_maddr), 64'({1'b0, 32'(m_base[1] + hw_off[1])}));
            chk("R4 store data", 64'(r_mwdata), 64'(8'(rx_exp)));
            rx_exp++;
            step_model(1);
         end
      end
   end

   task automatic wr(input int s, input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      if (s == 0) begin t_we = 1'b1; t_addr = a; t_wdata = d; end
      else begin r_we = 1'b1; r_addr = a; r_wdata = d; end
      @(negedge clk);
      t_we = 1'b0; r_we = 1'b0;
   endtask

   task automatic expect_reg(input int s, input logic [7:0] a, input logic [31:0] e,
                             input string req);
      logic [31:0] v;
      @(negedge clk);
      if (s == 0) t_addr = a; else r_addr = a;
      #1;
      v = (s == 0) ? t_rdata : r_rdata;
      chk(req, 64'(v), 64'(e));
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; slow = 1'b1; tog = 1'b0; m_ext = 1'b0; rx_exp = 'h10; rx_next = 8'h10;
      t_we = 0; t_addr = 0; t_wdata = 0; t_txr = 0;
      r_we = 0; r_addr = 0; r_wdata = 0; r_rxv = 0;
      for (int i = 0; i < 256; i++) begin tram[i] = 8'(i ^ 8'h5A); rram[i] = 8'h00; end
      for (int s = 0; s < 2; s++) begin hw_off[s] = 0; m_base[s] = 0; m_len[s] = 1; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state
      expect_reg(0, RA_EN, 0, "R10 reset enable");
      expect_reg(0, RA_VALID, 0, "R2 reset occupied");
      chk("R5 reset no request", 64'(t_req), 64'(0));
      chk("R7 reset irq", 64'(t_irq), 64'(0));
      expect_reg(1, RA_FLAG, 0, "R7 reset flags");

      // ---------------- outbound channel ----------------
      m_base[0] = 'h40; m_len[0] = 8;
      wr(0, RA_BASE, 'h40); wr(0, RA_LEN, 8); wr(0, RA_THR, 3);
      wr(0, RA_WPT, 5);
      expect_reg(0, RA_VALID, 5, "R2 occupied same wrap");
      expect_reg(0, RA_LEFT, 3, "R2 free same wrap");
      chk("R5 disabled no request", 64'(t_req), 64'(0));
      wr(0, RA_RPT, 3);
      expect_reg(0, RA_RPT, 0, "R6 hardware pointer write ignored");
      wr(0, RA_VALID, 7);
      expect_reg(0, RA_VALID, 5, "R6 count write ignored");

      t_txr = 1'b1;
      wr(0, RA_EN, 1);
      idle(30);
      expect_reg(0, RA_VALID, 0, "R3 all bytes sent");
      expect_reg(0, RA_RPT, 5, "R1 read pointer advanced");
      chk("R5 empty no request", 64'(t_req), 64'(0));
      chk("R7 disabled interrupt stays low", 64'(t_irq), 64'(0));

      wr(0, RA_EN, 0);
      wr(0, RA_WPT, 'h10003);
      expect_reg(0, RA_VALID, 6, "R2 occupied across wrap");
      expect_reg(0, RA_LEFT, 2, "R2 free across wrap");
      wr(0, RA_EN, 1);
      idle(30);
      expect_reg(0, RA_RPT, 'h10003, "R1 wrap flag inverted");
      wr(0, RA_EN, 0);

      // interrupt, set wins over clear
      wr(0, RA_IEN, 1);
      expect_reg(0, RA_FLAG, 1, "R7 outbound flag set");
      chk("R7 irq high", 64'(t_irq), 64'(1));
      wr(0, RA_FLAG, 1);
      expect_reg(0, RA_FLAG, 1, "R7 set wins over clear");
      wr(0, RA_WPT, 'h00001);
      wr(0, RA_FLAG, 1);
      expect_reg(0, RA_FLAG, 0, "R7 flag cleared");
      chk("R7 irq low", 64'(t_irq), 64'(0));
      wr(0, RA_IEN, 0);

      // stop handshake
      @(negedge clk); t_txr = 1'b0;
      wr(0, RA_EN, 1);
      idle(4);
      wr(0, RA_STOP, 1);
      expect_reg(0, RA_EN, 1, "R9 enable held while byte in flight");
      @(negedge clk); t_txr = 1'b1;
      idle(4);
      expect_reg(0, RA_EN, 0, "R9 enable dropped");
      wr(0, RA_EN, 1);
      expect_reg(0, RA_EN, 0, "R9 enable write ignored while stopped");
      expect_reg(0, RA_RPT, 'h10004, "R9 only the held byte moved");
      wr(0, RA_STOP, 0);

      // drain request
      wr(0, RA_FLUSH, 1);
      expect_reg(0, RA_FLUSH, 1, "R8 drain pending");
      wr(0, RA_EN, 1);
      idle(30);
      expect_reg(0, RA_FLUSH, 0, "R8 drain acknowledged");
      expect_reg(0, RA_RPT, 'h00001, "R1 drained across wrap");
      wr(0, RA_EN, 0);

      // address extension bit
      wr(0, RA_EXT, 1); m_ext = 1'b1;
      slow = 1'b0;
      wr(0, RA_WPT, 'h00004);
      wr(0, RA_EN, 1);
      idle(20);
      expect_reg(0, RA_VALID, 0, "R11 extended fetches done");
      wr(0, RA_EN, 0);

      // warm reset
      wr(0, RA_STOP, 1);
      wr(0, RA_WPT, 'h00006);
      wr(0, RA_RST, 1);
      hw_off[0] = 0;
      expect_reg(0, RA_EN, 0, "R10 enable cleared");
      expect_reg(0, RA_STOP, 0, "R10 stop cleared");
      expect_reg(0, RA_WPT, 0, "R10 write pointer cleared");
      expect_reg(0, RA_RPT, 0, "R10 read pointer cleared");
      expect_reg(0, RA_RST, 0, "R10 reset reads zero");

      // ---------------- inbound channel ----------------
      slow = 1'b1;
      m_base[1] = 'h80; m_len[1] = 4;
      wr(1, RA_BASE, 'h80); wr(1, RA_LEN, 4); wr(1, RA_THR, 2); wr(1, RA_IEN, 3);
      @(negedge clk); r_rxv = 1'b1;
      wr(1, RA_EN, 1);
      idle(20);
      expect_reg(1, RA_WPT, 'h10000, "R1 inbound wrap");
      expect_reg(1, RA_VALID, 4, "R2 inbound full");
      expect_reg(1, RA_LEFT, 0, "R2 inbound no space");
      chk("R5 full no request", 64'(r_req), 64'(0));
      expect_reg(1, RA_FLAG, 3, "R7 inbound both flags");
      chk("R7 inbound irq", 64'(r_irq), 64'(1));
      chk("R4 stored byte 0", 64'(rram['h80]), 64'(8'h10));
      chk("R4 stored byte 3", 64'(rram['h83]), 64'(8'h13));

      wr(1, RA_RPT, 'h00002);
      idle(10);
      expect_reg(1, RA_WPT, 'h10002, "R1 inbound after software read");
      expect_reg(1, RA_VALID, 4, "R2 inbound refilled");
      chk("R4 overwritten slot", 64'(rram['h81]), 64'(8'h15));
      wr(1, RA_WPT, 0);
      expect_reg(1, RA_WPT, 'h10002, "R6 inbound hardware pointer write ignored");
      wr(1, RA_FLAG, 3);
      expect_reg(1, RA_FLAG, 3, "R7 inbound set wins over clear");

      @(negedge clk); r_rxv = 1'b0;
      wr(1, RA_EN, 0);
      wr(1, RA_RPT, 'h10002);
      expect_reg(1, RA_VALID, 0, "R6 software read pointer taken");
      wr(1, RA_FLAG, 3);
      expect_reg(1, RA_FLAG, 0, "R7 inbound flags cleared");
      wr(1, RA_FLUSH, 1);
      expect_reg(1, RA_FLUSH, 0, "R8 inbound drain immediate");

      idle(3);
      finish_run();
   end
endmodule